// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit device virtual address into a physical address. It reads two 4-byte descriptors from memory to do this. The virtual address is split into three fields:

- bits 31:22 select the entry in the directory;
- bits 21:12 select the entry in the second-level table;
- bits 11:0 are the byte offset inside a 4 KB page.

Each table has 1024 entries and fills one 4 KB frame. The directory frame number comes from a base input. The walker issues one memory read at a time and returns either the translated address with the page's cache attributes, or a fault.

A descriptor fails when its present bit is clear. A leaf descriptor also fails when it lacks the permission the access needs. When a walk fails, the walker latches a syndrome for a control block to collect: the full virtual address, the access direction and the 5-bit requester id. The syndrome stays held until the control block acknowledges it, and the first fault is kept until then.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk goes to address {dir_pfn, va[31:22], 2'b00}, that is, directory frame base plus four times the directory index.
- R2: The second read goes to {d1[31:12], va[21:12], 2'b00}, where d1 is the first descriptor; descriptor bits 11:1 of d1 do not change it.
- R3: A first descriptor with bit 0 (present) clear ends the walk with rsp_fault=1 after exactly one memory read.
- R4: A second descriptor with bit 0 clear ends the walk with rsp_fault=1.
- R5: A read needs bit 1 of the second descriptor and a write needs bit 2; a walk lacking the needed bit ends with rsp_fault=1.
- R6: A successful walk returns rsp_fault=0, rsp_paddr={d2[31:12], va[11:0]} and rsp_attr=d2[8:3].
- R7: req_ready is high only while idle; mem_rd_valid is a one-cycle pulse, and no new read is issued before the previous response; the cycle after rsp_valid the walker is ready again.
- R8: On a fault with no syndrome pending, flt_valid rises together with rsp_valid, and flt_vaddr, flt_write and flt_id hold the request's values; while a syndrome is pending and not acknowledged, later faults leave it unchanged.
- R9: A one-cycle flt_ack clears flt_valid on the next cycle.
- R10: During reset req_ready=1, mem_rd_valid=0, rsp_valid=0 and flt_valid=0.
- R11: A faulting response reports rsp_paddr=0 and rsp_attr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request is taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_id | input | 5 | Requester bus id |
| dir_pfn | input | 20 | Frame number of the directory table |
| mem_rd_valid | output | 1 | One-cycle memory read strobe |
| mem_rd_addr | output | 32 | Descriptor read address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Descriptor read data |
| rsp_valid | output | 1 | Walk result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_attr | output | 6 | Cache attribute flags of the page |
| flt_valid | output | 1 | Fault syndrome pending |
| flt_vaddr | output | 32 | Faulting virtual address |
| flt_write | output | 1 | Faulting access was a write |
| flt_id | output | 5 | Faulting requester id |
| flt_ack | input | 1 | Syndrome acknowledge |

## Verification
The assertions assume that memory returns exactly one response per read. That response must come at least one cycle after the strobe, and mem_rsp_valid must stay low while no read is outstanding. They also assume that flt_ack is a single-cycle pulse and that dir_pfn is steady during a walk.

The bench meets these assumptions with its memory responder. The responder answers each strobe once, after a fixed latency, and drives the response for one cycle. The bench pulses the acknowledge only between walks.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int unsigned VA_W       = 32;
    localparam int unsigned OFF_W      = 12;
    localparam int unsigned IDX_W      = 10;
    localparam int unsigned ID_W       = 5;
    localparam int unsigned ATTR_W     = 6;
    localparam int unsigned DESC_W     = 32;
    localparam int unsigned ENT_SHIFT  = 2;
    localparam int unsigned PFN_W      = VA_W - OFF_W;
    localparam int unsigned BIT_PRES   = 0;
    localparam int unsigned BIT_RD     = 1;
    localparam int unsigned BIT_WR     = 2;
    localparam int unsigned ATTR_LSB   = 3;
    localparam int unsigned DIR_LSB    = OFF_W + IDX_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [VA_W-1:0] vaddr;
        logic            write;
        logic [ID_W-1:0] id;
    } walk_req_t;

    typedef struct packed {
        logic              fault;
        logic [VA_W-1:0]   paddr;
        logic [ATTR_W-1:0] attr;
    } walk_res_t;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
    import pw_pkg::*;
(
    input  logic [PFN_W-1:0] dir_pfn,
    input  logic [PFN_W-1:0] tbl_pfn,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             level2,
    output logic [VA_W-1:0]  walk_addr
);
    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    always_comb begin
        dir_idx = vaddr[DIR_LSB +: IDX_W];
        tbl_idx = vaddr[OFF_W +: IDX_W];
        if (level2) begin
            walk_addr = {tbl_pfn, tbl_idx, {ENT_SHIFT{1'b0}}};
        end else begin
            walk_addr = {dir_pfn, dir_idx, {ENT_SHIFT{1'b0}}};
        end
    end
endmodule

// File: rtl/pw_desc_check.sv
module pw_desc_check
    import pw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic              level2,
    input  logic              write,
    output logic              fault,
    output logic [PFN_W-1:0]  pfn,
    output logic [ATTR_W-1:0] attr
);
    logic present;
    logic perm_ok;

    always_comb begin
        present = desc[BIT_PRES];
        perm_ok = write ? desc[BIT_WR] : desc[BIT_RD];
        fault   = !present || (level2 && !perm_ok);
        pfn     = desc[DESC_W-1 -: PFN_W];
        attr    = desc[ATTR_LSB +: ATTR_W];
    end
endmodule

// File: rtl/pw_syndrome.sv
module pw_syndrome
    import pw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [VA_W-1:0] cap_vaddr,
    input  logic            cap_write,
    input  logic [ID_W-1:0] cap_id,
    input  logic            ack,
    output logic            valid,
    output logic [VA_W-1:0] vaddr,
    output logic            write,
    output logic [ID_W-1:0] id
);
    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] vaddr;
        logic            write;
        logic [ID_W-1:0] id;
    } syn_t;

    syn_t syn_d, syn_q;

    always_comb begin
        syn_d = syn_q;
        if (ack) begin
            syn_d.valid = 1'b0;
        end
        if (capture && (!syn_q.valid || ack)) begin
            syn_d.valid = 1'b1;
            syn_d.vaddr = cap_vaddr;
            syn_d.write = cap_write;
            syn_d.id    = cap_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_q <= '0;
        end else begin
            syn_q <= syn_d;
        end
    end

    assign valid = syn_q.valid;
    assign vaddr = syn_q.vaddr;
    assign write = syn_q.write;
    assign id    = syn_q.id;

    // R8: an unacknowledged syndrome is held unchanged
    p_syn_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ack) |=> (valid && $stable(vaddr) && $stable(id) && $stable(write)));

    // R9: acknowledge without a new fault clears the syndrome
    p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ack && !capture) |=> !valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [ID_W-1:0]   req_id,
    input  logic [PFN_W-1:0]  dir_pfn,
    output logic              mem_rd_valid,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              flt_valid,
    output logic [VA_W-1:0]   flt_vaddr,
    output logic              flt_write,
    output logic [ID_W-1:0]   flt_id,
    input  logic              flt_ack
);
    typedef struct packed {
        walk_state_e      state;
        walk_req_t        req;
        logic [PFN_W-1:0] tbl_pfn;
        walk_res_t        res;
    } walk_ctl_t;

    walk_ctl_t ctl_d, ctl_q;

    logic              chk_fault;
    logic [PFN_W-1:0]  chk_pfn;
    logic [ATTR_W-1:0] chk_attr;
    logic              fault_evt;
    logic              at_l2;

    assign at_l2 = (ctl_q.state == ST_L2_ISSUE) || (ctl_q.state == ST_L2_WAIT);

    pw_addr_gen u_addr (
        .dir_pfn   (dir_pfn),
        .tbl_pfn   (ctl_q.tbl_pfn),
        .vaddr     (ctl_q.req.vaddr),
        .level2    (at_l2),
        .walk_addr (mem_rd_addr)
    );

    pw_desc_check u_check (
        .desc   (mem_rsp_data),
        .level2 (at_l2),
        .write  (ctl_q.req.write),
        .fault  (chk_fault),
        .pfn    (chk_pfn),
        .attr   (chk_attr)
    );

    always_comb begin
        ctl_d     = ctl_q;
        fault_evt = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.req.vaddr = req_vaddr;
                    ctl_d.req.write = req_write;
                    ctl_d.req.id    = req_id;
                    ctl_d.state     = ST_L1_ISSUE;
                end
            end
            ST_L1_ISSUE: ctl_d.state = ST_L1_WAIT;
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (chk_fault) begin
                        ctl_d.res   = '{fault: 1'b1, paddr: '0, attr: '0};
                        fault_evt   = 1'b1;
                        ctl_d.state = ST_DONE;
                    end else begin
                        ctl_d.tbl_pfn = chk_pfn;
                        ctl_d.state   = ST_L2_ISSUE;
                    end
                end
            end
            ST_L2_ISSUE: ctl_d.state = ST_L2_WAIT;
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    if (chk_fault) begin
                        ctl_d.res = '{fault: 1'b1, paddr: '0, attr: '0};
                        fault_evt = 1'b1;
                    end else begin
                        ctl_d.res = '{fault: 1'b0,
                                      paddr: {chk_pfn, ctl_q.req.vaddr[OFF_W-1:0]},
                                      attr:  chk_attr};
                    end
                    ctl_d.state = ST_DONE;
                end
            end
            ST_DONE: ctl_d.state = ST_IDLE;
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready    = (ctl_q.state == ST_IDLE);
    assign mem_rd_valid = (ctl_q.state == ST_L1_ISSUE) || (ctl_q.state == ST_L2_ISSUE);
    assign rsp_valid    = (ctl_q.state == ST_DONE);
    assign rsp_fault    = ctl_q.res.fault;
    assign rsp_paddr    = ctl_q.res.paddr;
    assign rsp_attr     = ctl_q.res.attr;

    pw_syndrome u_syn (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (fault_evt),
        .cap_vaddr (ctl_q.req.vaddr),
        .cap_write (ctl_q.req.write),
        .cap_id    (ctl_q.req.id),
        .ack       (flt_ack),
        .valid     (flt_valid),
        .vaddr     (flt_vaddr),
        .write     (flt_write),
        .id        (flt_id)
    );

    // R7: a read strobe lasts one cycle
    p_single_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);

    // R7: the walker is ready right after a result
    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R11: faulting results carry no address or attributes
    p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_attr == '0));

    // R3: an absent directory entry ends the walk with a fault
    p_l1_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_L1_WAIT && mem_rsp_valid && !mem_rsp_data[BIT_PRES])
        |=> (rsp_valid && rsp_fault));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [4:0]  id;
        logic [31:0] d1;
        logic [31:0] d2;
        logic        flt;
        logic [31:0] pa;
        logic [5:0]  attr;
    } vec_t;

    localparam int NVEC = 7;
    localparam int LAT  = 3;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0040_1234, 1'b0, 5'd3,  32'h0020_0001, 32'h8765_41FF, 1'b0, 32'h8765_4234, 6'h3F},
        '{32'hFFC0_0FFF, 1'b1, 5'd31, 32'h0030_0001, 32'hABCD_E005, 1'b0, 32'hABCD_EFFF, 6'h00},
        '{32'h1234_5678, 1'b0, 5'd7,  32'h0030_0001, 32'hABCD_E005, 1'b1, 32'h0,         6'h00},
        '{32'h8000_0000, 1'b1, 5'd1,  32'h0060_0001, 32'h1111_1003, 1'b1, 32'h0,         6'h00},
        '{32'h0FF0_0ABC, 1'b0, 5'd9,  32'h0040_0000, 32'h0000_0007, 1'b1, 32'h0,         6'h00},
        '{32'h7654_3210, 1'b1, 5'd12, 32'h0070_0001, 32'h2222_2006, 1'b1, 32'h0,         6'h00},
        '{32'h003F_F800, 1'b0, 5'd0,  32'h0050_0FFF, 32'h0000_0043, 1'b0, 32'h0000_0800, 6'h08}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [4:0]  req_id = '0;
    logic [19:0] dir_pfn = 20'h00100;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic [5:0]  rsp_attr;
    logic        flt_valid, flt_write;
    logic [31:0] flt_vaddr;
    logic [4:0]  flt_id;
    logic        flt_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] cur_d1, cur_d2, exp_a1, exp_a2;
    int reads_seen = 0;

    always #2.5 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_id(req_id), .dir_pfn(dir_pfn),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_attr(rsp_attr), .flt_valid(flt_valid), .flt_vaddr(flt_vaddr),
        .flt_write(flt_write), .flt_id(flt_id), .flt_ack(flt_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: one response per strobe after LAT cycles
    initial begin
        @(negedge clk);
        forever begin
            if (mem_rd_valid) begin
                if (reads_seen == 0) begin
                    chk(mem_rd_addr == exp_a1, "R1 directory read address", mem_rd_addr, exp_a1);
                    mem_rsp_data = cur_d1;
                end else begin
                    chk(mem_rd_addr == exp_a2, "R2 table read address", mem_rd_addr, exp_a2);
                    mem_rsp_data = cur_d2;
                end
                reads_seen++;
                repeat (LAT) @(negedge clk);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic wr, input logic [4:0] id,
                        input logic [31:0] d1, input logic [31:0] d2);
        int n;
        cur_d1 = d1;
        cur_d2 = d2;
        exp_a1 = {dir_pfn, 12'h000} + 32'((va >> 22) * 4);
        exp_a2 = (d1 & 32'hFFFF_F000) + 32'(((va >> 12) & 32'h3FF) * 4);
        reads_seen = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        req_id    = id;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7 busy during walk", 32'(req_ready), 32'd0);
        n = 0;
        while (!rsp_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(rsp_valid == 1'b1, "R7 walk completes", 32'(rsp_valid), 32'd1);
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        flt_ack = 1'b1;
        @(negedge clk);
        flt_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1,    "R10 ready in reset", 32'(req_ready), 32'd1);
        chk(mem_rd_valid == 1'b0, "R10 no read in reset", 32'(mem_rd_valid), 32'd0);
        chk(rsp_valid == 1'b0,    "R10 no result in reset", 32'(rsp_valid), 32'd0);
        chk(flt_valid == 1'b0,    "R10 no syndrome in reset", 32'(flt_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            walk(VEC[i].va, VEC[i].wr, VEC[i].id, VEC[i].d1, VEC[i].d2);
            chk(rsp_fault == VEC[i].flt, "R3 R4 R5 R6 fault flag", 32'(rsp_fault), 32'(VEC[i].flt));
            chk(rsp_paddr == VEC[i].pa,  "R6 R11 physical address", rsp_paddr, VEC[i].pa);
            chk(rsp_attr == VEC[i].attr, "R6 R11 attributes", 32'(rsp_attr), 32'(VEC[i].attr));
            chk(reads_seen == ((VEC[i].d1[0]) ? 2 : 1), "R3 R7 read count",
                32'(reads_seen), (VEC[i].d1[0]) ? 32'd2 : 32'd1);
            chk(flt_valid == VEC[i].flt, "R8 syndrome valid", 32'(flt_valid), 32'(VEC[i].flt));
            if (VEC[i].flt) begin
                chk(flt_vaddr == VEC[i].va, "R8 syndrome address", flt_vaddr, VEC[i].va);
                chk(flt_write == VEC[i].wr, "R8 syndrome direction", 32'(flt_write), 32'(VEC[i].wr));
                chk(flt_id == VEC[i].id,    "R8 syndrome id", 32'(flt_id), 32'(VEC[i].id));
            end
            @(negedge clk);
            chk(req_ready == 1'b1, "R7 ready after result", 32'(req_ready), 32'd1);
            if (VEC[i].flt) begin
                ack_pulse();
                chk(flt_valid == 1'b0, "R9 ack clears syndrome", 32'(flt_valid), 32'd0);
            end
        end

        // R1 another directory base
        dir_pfn = 20'hA5A5A;
        walk(VEC[0].va, VEC[0].wr, VEC[0].id, VEC[0].d1, VEC[0].d2);
        chk(rsp_paddr == VEC[0].pa, "R1 result with moved directory", rsp_paddr, VEC[0].pa);

        // R8 first fault kept while pending
        walk(VEC[4].va, VEC[4].wr, VEC[4].id, VEC[4].d1, VEC[4].d2);
        walk(VEC[0].va, VEC[0].wr, VEC[0].id, VEC[0].d1, VEC[0].d2);
        walk(VEC[2].va, VEC[2].wr, VEC[2].id, VEC[2].d1, VEC[2].d2);
        chk(rsp_fault == 1'b1, "R5 second fault reported", 32'(rsp_fault), 32'd1);
        chk(flt_vaddr == VEC[4].va, "R8 first fault address kept", flt_vaddr, VEC[4].va);
        chk(flt_id == VEC[4].id, "R8 first fault id kept", 32'(flt_id), 32'(VEC[4].id));
        ack_pulse();
        chk(flt_valid == 1'b0, "R9 cleared after hold", 32'(flt_valid), 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule